// File: doc/BRIEF.md
# Bus Initiator Address-Phase Sequencer

This block is the initiator side of a shared 32-bit multiplexed parallel bus. It takes one request at a time. A request holds a 64-bit address, a 4-bit command, a direction flag, active-low byte enables, a burst length and a latency-timer setting. The block drives the address and command cycles and waits for a target to claim the transfer. It then counts data phases until the burst is finished.

When the upper half of the address is zero, the block issues a single address cycle. Otherwise it issues a two-cycle dual-address phase. The first cycle carries the low half of the address with the dual-address command code. The second cycle carries the high half with the real command. If no target claims the transfer in time, the block reports a master abort. A latency timer, loaded when the request is accepted, ends a long burst early once it has run out and the grant has been taken away.

The state machine has eight states:
- `S_IDLE` goes to `S_ADDR` (upper half zero) or to `S_DLO` (upper half non-zero) when a request arrives.
- `S_ADDR` goes to `S_CLAIM`.
- `S_DLO` goes to `S_DHI`, and `S_DHI` goes to `S_CLAIM`.
- `S_CLAIM` goes to `S_DATA` on a claim, or to `S_ABORT` when the window runs out.
- `S_DATA` goes to `S_FIN` when the final phase completes.
- `S_FIN` and `S_ABORT` both return to `S_IDLE`.

Top module: `busi_addr_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `bus_ad`=0, `bus_cbe_n`=4'hF, and `done`=`mabort`=0. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the block is idle again.
- R2: When `req_addr[63:32]` is zero, the single cycle after acceptance is the only address cycle. In it `addr_phase`=1, `bus_ad`=`req_addr[31:0]` and `bus_cbe_n`=`req_cmd`.
- R3: When `req_addr[63:32]` is non-zero, two address cycles follow acceptance. The first carries `req_addr[31:0]` with `bus_cbe_n`=4'b1101 (the dual-address code). The second carries `req_addr[63:32]` with `bus_cbe_n`=`req_cmd`.
- R4: From the cycle after the last address cycle until the burst ends, `bus_cbe_n` carries `req_be_n`. These are active low, and bit i enables byte lane i. `addr_phase` is 0 in these cycles.
- R5: `bus_wr` equals `req_write` in every cycle of the transaction, so all data phases move in one direction.
- R6: The claim window is the 4 cycles after the last address cycle. If `tgt_claim` is high at the edge ending any of these cycles, `data_phase` is 1 from the next cycle.
- R7: If `tgt_claim` stays low through all 4 window cycles, the next cycle shows `done`=1, `mabort`=1 and `phases_done`=0 for one cycle.
- R8: A data phase completes on each edge where `data_phase` and `phase_ack` are both high. The burst ends when the completed count reaches the length. A length of 0 is treated as 1.
- R9: The latency timer loads `lat_cfg` on acceptance and counts down by one per clock until it reaches zero. It is expired when zero. If a phase completes while the timer is expired and `gnt` is low, that phase is the last one. While `phase_ack` is low, the burst does not end.
- R10: The cycle after the final data phase shows `done`=1, `mabort`=0 and `phases_done` equal to the completed count, for exactly one cycle. The block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_addr | input | 64 | Transfer address |
| req_cmd | input | 4 | Bus command code |
| req_write | input | 1 | 1: initiator to target, 0: target to initiator |
| req_be_n | input | 4 | Active-low byte enables for the data phases |
| req_len | input | 8 | Number of data phases (0 means 1) |
| lat_cfg | input | 8 | Latency timer load value |
| tgt_claim | input | 1 | A target claims the transfer |
| phase_ack | input | 1 | Current data phase completes at this edge |
| gnt | input | 1 | Bus grant; low means the grant has been removed |
| bus_ad | output | 32 | Address half during address cycles, else 0 |
| bus_cbe_n | output | 4 | Command during address cycles, byte enables afterwards |
| bus_wr | output | 1 | Direction of the transaction in progress |
| addr_phase | output | 1 | An address cycle is on the bus |
| data_phase | output | 1 | A data phase is in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| mabort | output | 1 | One-cycle master-abort pulse |
| phases_done | output | 8 | Completed data phases, valid while `done` is high |

## Verification
A burst can reach its programmed length in the same cycle that the latency timer, already expired and with the grant removed, also calls for it to stop. The bench forces this by dropping `gnt` and setting a zero timer while the last counted phase is acknowledged. It then judges that `phases_done` equals the length, with no extra phase and no early stop. A second collision is a claim in the fourth and final window cycle, the same edge on which the timeout would fire. The bench expects data phases there, not an abort.

// File: rtl/busi_pkg.sv
package busi_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_DLO,
        S_DHI,
        S_CLAIM,
        S_DATA,
        S_FIN,
        S_ABORT
    } seq_state_t;

endpackage

// File: rtl/busi_lat_timer.sv
module busi_lat_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R9: the count only moves downward between loads
    assert_lat_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/busi_claim_watch.sv
module busi_claim_watch #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic claim,
    output logic timeout
);

    localparam int CNTW = $clog2(WIN + 1);

    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= cnt_q + CNTW'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign timeout = active && !claim && (cnt_q == CNTW'(WIN - 1));

    // R6: the waiting period never runs past the window
    assert_win_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < CNTW'(WIN)));

endmodule

// File: rtl/busi_addr_seq.sv
module busi_addr_seq
    import busi_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          LW        = 8,
    parameter int          TW        = 8,
    parameter int          CLAIM_WIN = 4,
    parameter logic [3:0]  DUAL_CMD  = 4'b1101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2*DW-1:0]   req_addr,
    input  logic [DW/8-1:0]   req_cmd,
    input  logic              req_write,
    input  logic [DW/8-1:0]   req_be_n,
    input  logic [LW-1:0]     req_len,
    input  logic [TW-1:0]     lat_cfg,
    input  logic              tgt_claim,
    input  logic              phase_ack,
    input  logic              gnt,
    output logic [DW-1:0]     bus_ad,
    output logic [DW/8-1:0]   bus_cbe_n,
    output logic              bus_wr,
    output logic              addr_phase,
    output logic              data_phase,
    output logic              done,
    output logic              mabort,
    output logic [LW-1:0]     phases_done
);

    localparam int AW  = 2 * DW;
    localparam int BEW = DW / 8;

    seq_state_t state_q, state_d;

    logic [AW-1:0]  addr_q;
    logic [BEW-1:0] cmd_q;
    logic [BEW-1:0] be_q;
    logic           wr_q;
    logic [LW-1:0]  len_q;
    logic [LW-1:0]  cnt_q;
    logic [LW-1:0]  cnt_inc;
    logic           accept;
    logic           lat_exp;
    logic           claim_to;
    logic           last_ok;

    assign accept  = (state_q == S_IDLE) && req_valid;
    assign cnt_inc = cnt_q + LW'(1);
    assign last_ok = phase_ack && ((cnt_inc == len_q) || (lat_exp && !gnt));

    busi_lat_timer #(.TW(TW)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (lat_cfg),
        .expired  (lat_exp)
    );

    busi_claim_watch #(.WIN(CLAIM_WIN)) u_claim (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == S_CLAIM),
        .claim   (tgt_claim),
        .timeout (claim_to)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // captured request and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            be_q   <= '1;
            wr_q   <= 1'b0;
            len_q  <= LW'(1);
            cnt_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            cmd_q  <= req_cmd;
            be_q   <= req_be_n;
            wr_q   <= req_write;
            len_q  <= (req_len == '0) ? LW'(1) : req_len;
            cnt_q  <= '0;
        end else if ((state_q == S_DATA) && phase_ack) begin
            cnt_q  <= cnt_inc;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid)
                         state_d = (req_addr[AW-1:DW] != '0) ? S_DLO : S_ADDR;
            S_ADDR:  state_d = S_CLAIM;
            S_DLO:   state_d = S_DHI;
            S_DHI:   state_d = S_CLAIM;
            S_CLAIM: if (tgt_claim)     state_d = S_DATA;
                     else if (claim_to) state_d = S_ABORT;
            S_DATA:  if (last_ok) state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            S_ABORT: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        bus_ad      = '0;
        bus_cbe_n   = '1;
        bus_wr      = wr_q;
        addr_phase  = 1'b0;
        data_phase  = 1'b0;
        done        = 1'b0;
        mabort      = 1'b0;
        phases_done = '0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                bus_wr    = 1'b0;
            end
            S_ADDR: begin
                bus_ad     = addr_q[DW-1:0];
                bus_cbe_n  = cmd_q;
                addr_phase = 1'b1;
            end
            S_DLO: begin
                bus_ad     = addr_q[DW-1:0];
                bus_cbe_n  = DUAL_CMD;
                addr_phase = 1'b1;
            end
            S_DHI: begin
                bus_ad     = addr_q[AW-1:DW];
                bus_cbe_n  = cmd_q;
                addr_phase = 1'b1;
            end
            S_CLAIM: bus_cbe_n = be_q;
            S_DATA: begin
                bus_cbe_n  = be_q;
                data_phase = 1'b1;
            end
            S_FIN: begin
                done        = 1'b1;
                phases_done = cnt_q;
            end
            S_ABORT: begin
                done   = 1'b1;
                mabort = 1'b1;
            end
        endcase
    end

    assert_single_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR) |-> (addr_q[AW-1:DW] == '0));

    assert_dual_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DLO) |=> ((state_q == S_DHI) && addr_phase
                                && (bus_ad == $past(addr_q[AW-1:DW]))));

    assert_one_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && $past(data_phase)) |-> $stable(bus_wr));

    assert_abort_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mabort |-> (done && (phases_done == '0)));

    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_phase |-> (cnt_q < len_q));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

endmodule

// File: tb/sim_busi_addr_seq.sv
module sim_busi_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic [3:0]  req_cmd;
    logic        req_write;
    logic [3:0]  req_be_n;
    logic [7:0]  req_len;
    logic [7:0]  lat_cfg;
    logic        tgt_claim;
    logic        phase_ack;
    logic        gnt;
    logic [31:0] bus_ad;
    logic [3:0]  bus_cbe_n;
    logic        bus_wr;
    logic        addr_phase;
    logic        data_phase;
    logic        done;
    logic        mabort;
    logic [7:0]  phases_done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    busi_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_write(req_write),
        .req_be_n(req_be_n), .req_len(req_len), .lat_cfg(lat_cfg),
        .tgt_claim(tgt_claim), .phase_ack(phase_ack), .gnt(gnt),
        .bus_ad(bus_ad), .bus_cbe_n(bus_cbe_n), .bus_wr(bus_wr),
        .addr_phase(addr_phase), .data_phase(data_phase), .done(done),
        .mabort(mabort), .phases_done(phases_done)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input logic [7:0] l);
        return (l == 8'd0) ? 1 : int'(l);
    endfunction

    // one full transaction; gdrop: data cycles before gnt falls
    task automatic run_txn(input logic [63:0] a, input logic [3:0] c, input logic w,
                           input logic [3:0] be, input logic [7:0] l, input logic [7:0] cfg,
                           input int cdly, input int gdrop, input int ackpct);
        int j, cnt, d, lenx;
        bit claimed, fin, ack, g, expd;
        lenx = eff_len(l);
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_write = w;
        req_be_n = be; req_len = l; lat_cfg = cfg;
        gnt = 1'b1; tgt_claim = 1'b0; phase_ack = 1'b0;
        @(posedge clk); j = 0;
        @(negedge clk); req_valid = 1'b0;
        check(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
        if (a[63:32] != 32'd0) begin
            check(addr_phase && bus_ad == a[31:0] && bus_cbe_n == 4'b1101,
                  "R3 first dual cycle", {bus_cbe_n, bus_ad}, {4'b1101, a[31:0]});
            @(posedge clk); j++;
            @(negedge clk);
            check(addr_phase && bus_ad == a[63:32] && bus_cbe_n == c,
                  "R3 second dual cycle", {bus_cbe_n, bus_ad}, {c, a[63:32]});
        end else begin
            check(addr_phase && bus_ad == a[31:0] && bus_cbe_n == c,
                  "R2 single address cycle", {bus_cbe_n, bus_ad}, {c, a[31:0]});
        end
        @(posedge clk); j++;
        claimed = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(bus_cbe_n == be && !addr_phase, "R4 enables in claim wait", bus_cbe_n, be);
            tgt_claim = (k == cdly);
            claimed = (k == cdly);
            @(posedge clk); j++;
            if (claimed) break;
        end
        @(negedge clk); tgt_claim = 1'b0;
        if (!claimed) begin
            check(done && mabort && phases_done == 8'd0, "R7 master abort",
                  {done, mabort, phases_done}, {1'b1, 1'b1, 8'd0});
        end else begin
            cnt = 0; d = 0; fin = 1'b0;
            while (!fin && d < 2000) begin
                check(data_phase == 1'b1, "R6 data after claim", data_phase, 1);
                check(bus_wr == w, "R5 direction held", bus_wr, w);
                check(bus_cbe_n == be, "R4 enables in data", bus_cbe_n, be);
                ack = ($urandom % 100) < ackpct;
                g = (d < gdrop);
                phase_ack = ack; gnt = g;
                expd = (j >= int'(cfg));
                fin = ack && ((cnt + 1 == lenx) || (expd && !g));
                @(posedge clk); j++;
                if (ack) cnt++;
                d++;
                @(negedge clk);
            end
            phase_ack = 1'b0; gnt = 1'b1;
            check(done && !mabort && phases_done == 8'(cnt), "R8 R9 R10 completed count",
                  {done, mabort, phases_done}, {1'b1, 1'b0, 8'(cnt)});
        end
        @(posedge clk);
        @(negedge clk);
        check(!done && req_ready, "R10 single pulse then idle", {done, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_cmd = '0; req_write = 1'b0;
        req_be_n = '1; req_len = '0; lat_cfg = '0; tgt_claim = 1'b0;
        phase_ack = 1'b0; gnt = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(req_ready && bus_ad == 0 && bus_cbe_n == 4'hF && !done && !mabort,
              "R1 reset state", {req_ready, bus_cbe_n, done, mabort}, {1'b1, 4'hF, 2'b00});

        // R2 upper half zero, full burst
        run_txn(64'h0000_0000_1234_5678, 4'h7, 1'b1, 4'b0000, 8'd4, 8'd200, 0, 1000, 100);
        // R3 only the top bit set
        run_txn(64'h8000_0000_0000_0040, 4'h6, 1'b0, 4'b1010, 8'd3, 8'd200, 1, 1000, 100);
        // R6 claim in the last window cycle
        run_txn(64'h0000_0000_0000_1000, 4'h6, 1'b0, 4'b0011, 8'd2, 8'd200, 3, 1000, 100);
        // R7 no claim
        run_txn(64'h0000_0001_0000_2000, 4'h7, 1'b1, 4'b0000, 8'd5, 8'd200, 9, 1000, 100);
        // R8 length zero acts as one
        run_txn(64'h0000_0000_0000_3000, 4'h7, 1'b1, 4'b1110, 8'd0, 8'd200, 0, 1000, 100);
        // R9 timer zero, grant gone: one phase only
        run_txn(64'h0000_0000_0000_4000, 4'h6, 1'b0, 4'b0000, 8'd8, 8'd0, 0, 0, 100);
        // R9 stop waits for acknowledge
        run_txn(64'h0000_0000_0000_5000, 4'h6, 1'b0, 4'b0000, 8'd8, 8'd0, 0, 0, 30);
        // R8 R9 collision: length reached while timer stop also applies
        run_txn(64'h0000_0000_0000_6000, 4'h7, 1'b1, 4'b0101, 8'd3, 8'd0, 0, 2, 100);

        for (int n = 0; n < 80; n++) begin
            logic [63:0] a;
            a = {(($urandom % 2) == 0) ? 32'd0 : $urandom, $urandom};
            run_txn(a, 4'($urandom), 1'($urandom), 4'($urandom),
                    (($urandom % 10) == 0) ? 8'd0 : 8'(1 + $urandom % 8),
                    8'($urandom % 12), int'($urandom % 6), int'($urandom % 10),
                    40 + int'($urandom % 61));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule